// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits at the front of a single-precision fused multiply-add unit that computes `z + x*y` and its three sign variants. It takes the three raw operand words, classifies each one, applies the sign controls of the selected variant and decides whether the final result is already fixed by operand classes alone. That is the case for NaN inputs, infinities, invalid operations and products that are exactly zero. When the result is fixed, the block delivers the final 32-bit word and the invalid-operation flag. Otherwise it raises `compute`, and the arithmetic datapath (alignment, addition, normalisation and rounding) produces the result. That datapath is outside this block.

The block is purely combinational. Its resolution path is a fixed chain of decisions: NaN selection first, then the product class (invalid, infinite, zero or finite), then the addend class. The product class is an enumerated decision variable with four named values: `PR_INVALID`, `PR_INF`, `PR_ZERO` and `PR_FINITE`. The final selector has seven named outcomes: `OUT_COMPUTE`, `OUT_NAN_QUIET`, `OUT_NAN_PASS`, `OUT_INVALID`, `OUT_INF`, `OUT_ZERO` and `OUT_ADDEND`. Each input combination takes exactly one route through them.

Top module: `fma_special_resolver`

## Requirements
- R1: Each operand is classified from its bits. Exponent field 0 with fraction 0 is zero. Exponent 0 with a nonzero fraction is subnormal. An all-ones exponent with fraction 0 is infinity. An all-ones exponent with fraction MSB (bit 22) set is a quiet NaN. An all-ones exponent with a nonzero fraction whose MSB is clear is a signalling NaN. Every other word is normal.
- R2: The effective product sign is `x[31] ^ y[31] ^ neg_prod`, and the effective addend sign is `z[31] ^ neg_add`. Plain multiply-add uses neither control. Multiply-subtract sets `neg_add`. Negated multiply-add sets both. Negated multiply-subtract sets `neg_prod` only.
- R3: If any operand is a NaN, a signalling NaN is chosen ahead of any quiet NaN. Within each kind, z wins over x, and x wins over y. `compute` is low whenever any operand is a NaN.
- R4: A chosen signalling NaN sets `invalid` and returns that operand's word with bit 22 set. Its sign and remaining payload are unchanged.
- R5: A chosen quiet NaN is returned bit for bit and leaves `invalid` low.
- R6: Infinity times zero, in either order and with no NaN present, sets `invalid` and returns the default NaN 0x7FC00000.
- R7: For an infinite product, if z is infinite with an effective sign different from the product sign, the block sets `invalid` and returns the default NaN. Otherwise it returns an infinity carrying the product sign.
- R8: For a finite nonzero product and an infinite z, the block returns an infinity carrying the effective addend sign.
- R9: For a zero product, an infinite z returns an infinity with the effective addend sign. A finite nonzero z (normal or subnormal) returns z's magnitude bits with the effective addend sign.
- R10: For a zero product and a zero z, equal effective signs return a zero of that sign. Different signs return +0 (0x00000000), except when `rmode` is 2'b11 (toward minus infinity), which returns -0 (0x80000000). The other `rmode` codes (00 nearest, 01 toward zero, 10 toward plus infinity) all give +0.
- R11: `compute` is high exactly when x and y are both finite and nonzero, z is finite, and no NaN is present. While it is high, `result` is 0 and `invalid` is low.
- R12: `invalid` is high only in the cases named in R4, R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| z_bits | input | 32 | Addend operand word |
| x_bits | input | 32 | First multiplicand word |
| y_bits | input | 32 | Second multiplicand word |
| neg_prod | input | 1 | Invert the product sign |
| neg_add | input | 1 | Invert the addend sign |
| rmode | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| result | output | 32 | Resolved result word; 0 while `compute` is high |
| invalid | output | 1 | Invalid-operation flag |
| compute | output | 1 | No special case applies; the arithmetic datapath must produce the result |

## Verification
The sweep crosses positive and negative samples of all six classes for all three operands with every negate setting and rounding mode. This covers every precedence collision. A resolver with the NaN order reversed would return x's payload where z's is due. One that quieted every NaN would raise `invalid` on a plain quiet NaN. The sweep also targets the signed-zero cancellation. A design that ignored the rounding mode would give +0 under round-toward-minus-infinity, and one that dropped `neg_add` would return z with its stored sign in the multiply-subtract variants. Opposite-signed infinities must turn into the default NaN with `invalid` raised, not into a silent infinity. Subnormal multiplicands must still route to `compute` and not be treated as zero.

// File: rtl/fma_sr_pkg.sv
package fma_sr_pkg;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_SUB,
        CL_NORM,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } opclass_e;

    typedef enum logic [1:0] {
        PR_INVALID,
        PR_INF,
        PR_ZERO,
        PR_FINITE
    } prodclass_e;

    typedef enum logic [2:0] {
        OUT_COMPUTE,
        OUT_NAN_QUIET,
        OUT_NAN_PASS,
        OUT_INVALID,
        OUT_INF,
        OUT_ZERO,
        OUT_ADDEND
    } outsel_e;

    localparam int          N_OPS   = 3;
    localparam int          OP_Z    = 0;
    localparam int          OP_X    = 1;
    localparam int          OP_Y    = 2;
    localparam logic [1:0]  RM_DOWN = 2'b11;

    function automatic logic is_nan(input opclass_e c);
        return (c == CL_QNAN) || (c == CL_SNAN);
    endfunction

    function automatic logic is_finite_nz(input opclass_e c);
        return (c == CL_SUB) || (c == CL_NORM);
    endfunction

endpackage

// File: rtl/fma_sr_classify.sv
module fma_sr_classify
    import fma_sr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_bits,
    output opclass_e              op_cls
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_zero;

    assign exp_f     = op_bits[FRAC_W +: EXP_W];
    assign frac_f    = op_bits[FRAC_W-1:0];
    assign exp_ones  = &exp_f;
    assign exp_zero  = ~|exp_f;
    assign frac_zero = ~|frac_f;

    always_comb begin
        unique case ({exp_ones, exp_zero})
            2'b10: begin
                if (frac_zero)                op_cls = CL_INF;
                else if (frac_f[FRAC_W-1])    op_cls = CL_QNAN;
                else                          op_cls = CL_SNAN;
            end
            2'b01:   op_cls = frac_zero ? CL_ZERO : CL_SUB;
            default: op_cls = CL_NORM;
        endcase
    end

    // R1: a NaN class always carries a nonzero fraction
    always_comb begin
        a_r1_nan_has_payload: assert (!is_nan(op_cls) || !frac_zero);
    end

endmodule

// File: rtl/fma_sr_nan_pick.sv
module fma_sr_nan_pick
    import fma_sr_pkg::*;
(
    input  opclass_e    cls [N_OPS],
    output logic        nan_hit,
    output logic        nan_sig,
    output logic [1:0]  nan_idx
);

    always_comb begin
        nan_hit = 1'b0;
        nan_sig = 1'b0;
        nan_idx = 2'd0;
        // quiet pass: scan from the back so the earliest operand wins
        for (int i = N_OPS - 1; i >= 0; i--) begin
            if (cls[i] == CL_QNAN) begin
                nan_hit = 1'b1;
                nan_idx = 2'(i);
            end
        end
        // signalling pass overrides any quiet choice
        for (int i = N_OPS - 1; i >= 0; i--) begin
            if (cls[i] == CL_SNAN) begin
                nan_hit = 1'b1;
                nan_sig = 1'b1;
                nan_idx = 2'(i);
            end
        end
    end

    // R3: a signalling pick must point at a signalling operand
    always_comb begin
        a_r3_sig_points_snan: assert (!nan_sig ||
            (nan_idx == 2'd0 && cls[0] == CL_SNAN) ||
            (nan_idx == 2'd1 && cls[1] == CL_SNAN) ||
            (nan_idx == 2'd2 && cls[2] == CL_SNAN));
    end

endmodule

// File: rtl/fma_sr_special.sv
module fma_sr_special
    import fma_sr_pkg::*;
(
    input  opclass_e    z_cls,
    input  opclass_e    x_cls,
    input  opclass_e    y_cls,
    input  logic        prod_sgn,
    input  logic        add_sgn,
    input  logic [1:0]  rmode,
    output outsel_e     sel,
    output logic        out_sgn
);

    prodclass_e prod_cls;
    logic       x_inf, y_inf, x_zero, y_zero;

    assign x_inf  = (x_cls == CL_INF);
    assign y_inf  = (y_cls == CL_INF);
    assign x_zero = (x_cls == CL_ZERO);
    assign y_zero = (y_cls == CL_ZERO);

    always_comb begin
        if ((x_inf && y_zero) || (x_zero && y_inf)) prod_cls = PR_INVALID;
        else if (x_inf || y_inf)                    prod_cls = PR_INF;
        else if (x_zero || y_zero)                  prod_cls = PR_ZERO;
        else                                        prod_cls = PR_FINITE;
    end

    always_comb begin
        sel     = OUT_COMPUTE;
        out_sgn = 1'b0;
        unique case (prod_cls)
            PR_INVALID: sel = OUT_INVALID;
            PR_INF: begin
                if (z_cls == CL_INF && add_sgn != prod_sgn) begin
                    sel = OUT_INVALID;
                end else begin
                    sel     = OUT_INF;
                    out_sgn = prod_sgn;
                end
            end
            PR_ZERO: begin
                unique case (z_cls)
                    CL_INF: begin
                        sel     = OUT_INF;
                        out_sgn = add_sgn;
                    end
                    CL_ZERO: begin
                        sel     = OUT_ZERO;
                        out_sgn = (add_sgn == prod_sgn) ? add_sgn
                                                        : (rmode == RM_DOWN);
                    end
                    default: begin
                        sel     = OUT_ADDEND;
                        out_sgn = add_sgn;
                    end
                endcase
            end
            PR_FINITE: begin
                if (z_cls == CL_INF) begin
                    sel     = OUT_INF;
                    out_sgn = add_sgn;
                end
            end
            default: sel = OUT_COMPUTE;
        endcase
    end

endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
    import fma_sr_pkg::*;
#(
    parameter int                        EXP_W       = 8,
    parameter int                        FRAC_W      = 23,
    parameter logic [EXP_W+FRAC_W:0]     DEFAULT_NAN = 32'h7FC0_0000,
    parameter int                        QUIET_BIT   = FRAC_W - 1
) (
    input  logic [EXP_W+FRAC_W:0] z_bits,
    input  logic [EXP_W+FRAC_W:0] x_bits,
    input  logic [EXP_W+FRAC_W:0] y_bits,
    input  logic                  neg_prod,
    input  logic                  neg_add,
    input  logic [1:0]            rmode,
    output logic [EXP_W+FRAC_W:0] result,
    output logic                  invalid,
    output logic                  compute
);

    localparam int W = 1 + EXP_W + FRAC_W;

    logic [W-1:0] op_bits [N_OPS];
    opclass_e     op_cls  [N_OPS];

    assign op_bits[OP_Z] = z_bits;
    assign op_bits[OP_X] = x_bits;
    assign op_bits[OP_Y] = y_bits;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fma_sr_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) i_cls (
            .op_bits (op_bits[g]),
            .op_cls  (op_cls[g])
        );
    end

    logic prod_sgn, add_sgn;
    assign prod_sgn = x_bits[W-1] ^ y_bits[W-1] ^ neg_prod;
    assign add_sgn  = z_bits[W-1] ^ neg_add;

    logic       nan_hit, nan_sig;
    logic [1:0] nan_idx;

    fma_sr_nan_pick i_nan (
        .cls     (op_cls),
        .nan_hit (nan_hit),
        .nan_sig (nan_sig),
        .nan_idx (nan_idx)
    );

    outsel_e sp_sel;
    logic    sp_sgn;

    fma_sr_special i_spec (
        .z_cls    (op_cls[OP_Z]),
        .x_cls    (op_cls[OP_X]),
        .y_cls    (op_cls[OP_Y]),
        .prod_sgn (prod_sgn),
        .add_sgn  (add_sgn),
        .rmode    (rmode),
        .sel      (sp_sel),
        .out_sgn  (sp_sgn)
    );

    logic [W-1:0] nan_src;
    always_comb begin
        unique case (nan_idx)
            2'd1:    nan_src = x_bits;
            2'd2:    nan_src = y_bits;
            default: nan_src = z_bits;
        endcase
    end

    outsel_e fin_sel;
    always_comb begin
        if (nan_hit) fin_sel = nan_sig ? OUT_NAN_QUIET : OUT_NAN_PASS;
        else         fin_sel = sp_sel;
    end

    always_comb begin
        result  = '0;
        invalid = 1'b0;
        compute = 1'b0;
        unique case (fin_sel)
            OUT_NAN_QUIET: begin
                result            = nan_src;
                result[QUIET_BIT] = 1'b1;
                invalid           = 1'b1;
            end
            OUT_NAN_PASS: result = nan_src;
            OUT_INVALID: begin
                result  = DEFAULT_NAN;
                invalid = 1'b1;
            end
            OUT_INF:    result = {sp_sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            OUT_ZERO:   result = {sp_sgn, {(W-1){1'b0}}};
            OUT_ADDEND: result = {sp_sgn, z_bits[W-2:0]};
            OUT_COMPUTE: compute = 1'b1;
            default:     compute = 1'b1;
        endcase
    end

    // Assertions relating the separate decision pieces
    logic any_nan, any_snan;
    assign any_nan  = is_nan(op_cls[OP_Z]) || is_nan(op_cls[OP_X]) || is_nan(op_cls[OP_Y]);
    assign any_snan = (op_cls[OP_Z] == CL_SNAN) || (op_cls[OP_X] == CL_SNAN) ||
                      (op_cls[OP_Y] == CL_SNAN);

    always_comb begin
        // R11: handing off to the datapath leaves the outputs clear
        a_r11_compute_clean: assert (!compute || (result == '0 && !invalid));
        // R3: no hand-off while any NaN is present
        a_r3_nan_blocks_compute: assert (!any_nan || !compute);
        // R5: quiet NaNs alone never raise the flag
        a_r5_qnan_no_flag: assert (!any_nan || any_snan || !invalid);
        // R12: a flagged result is always a NaN word
        a_r12_invalid_is_nan: assert (!invalid ||
            (&result[FRAC_W +: EXP_W] && |result[FRAC_W-1:0]));
        // R8: finite nonzero product against infinite addend
        a_r8_inf_addend: assert (!(op_cls[OP_Z] == CL_INF &&
            is_finite_nz(op_cls[OP_X]) && is_finite_nz(op_cls[OP_Y])) ||
            result == {add_sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}});
        // R6: infinity times zero gives the default NaN
        a_r6_inf_times_zero: assert (any_nan ||
            !((op_cls[OP_X] == CL_INF && op_cls[OP_Y] == CL_ZERO) ||
              (op_cls[OP_X] == CL_ZERO && op_cls[OP_Y] == CL_INF)) ||
            (result == DEFAULT_NAN && invalid));
    end

endmodule

// File: tb/test_fma_special_resolver.sv
module test_fma_special_resolver;

    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 60000;
    localparam int N_SAMP       = 12;

    logic        clk = 1'b0;
    logic [31:0] z_bits, x_bits, y_bits;
    logic        neg_prod, neg_add;
    logic [1:0]  rmode;
    logic [31:0] result;
    logic        invalid, compute;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fma_special_resolver i_fma_special_resolver (
        .z_bits   (z_bits),
        .x_bits   (x_bits),
        .y_bits   (y_bits),
        .neg_prod (neg_prod),
        .neg_add  (neg_add),
        .rmode    (rmode),
        .result   (result),
        .invalid  (invalid),
        .compute  (compute)
    );

    // Two samples per class, one of each sign (R1 classes)
    function automatic logic [31:0] samp(input int k);
        case (k)
            0:  return 32'h0000_0000;  // zero
            1:  return 32'h8000_0000;
            2:  return 32'h0000_0001;  // subnormal
            3:  return 32'h807F_FFFF;
            4:  return 32'h3F80_0000;  // normal
            5:  return 32'hC049_0FDB;
            6:  return 32'h7F80_0000;  // infinity
            7:  return 32'hFF80_0000;
            8:  return 32'h7FC0_0000;  // quiet NaN
            9:  return 32'hFFC1_2345;
            10: return 32'h7F80_0001;  // signalling NaN
            default: return 32'hFFA0_0000;
        endcase
    endfunction

    function automatic bit f_nan(input logic [31:0] b);
        return (b[30:23] == 8'hFF) && (b[22:0] != 0);
    endfunction
    function automatic bit f_snan(input logic [31:0] b);
        return f_nan(b) && !b[22];
    endfunction
    function automatic bit f_inf(input logic [31:0] b);
        return (b[30:23] == 8'hFF) && (b[22:0] == 0);
    endfunction
    function automatic bit f_zero(input logic [31:0] b);
        return b[30:0] == 0;
    endfunction

    task automatic model(input logic [31:0] z, x, y, input bit np, na,
                         input logic [1:0] rm, output logic [31:0] r,
                         output bit inv, output bit cmp, output string tag);
        bit ps, as;
        ps  = x[31] ^ y[31] ^ np;  // R2
        as  = z[31] ^ na;
        r   = 32'h0;
        inv = 1'b0;
        cmp = 1'b0;
        if (f_snan(z) || f_snan(x) || f_snan(y)) begin
            r   = f_snan(z) ? z : (f_snan(x) ? x : y);
            r   = r | 32'h0040_0000;
            inv = 1'b1;
            tag = "R3/R4";
        end else if (f_nan(z) || f_nan(x) || f_nan(y)) begin
            r   = f_nan(z) ? z : (f_nan(x) ? x : y);
            tag = "R3/R5";
        end else if ((f_inf(x) && f_zero(y)) || (f_zero(x) && f_inf(y))) begin
            r   = 32'h7FC0_0000;
            inv = 1'b1;
            tag = "R6";
        end else if (f_inf(x) || f_inf(y)) begin
            tag = "R7";
            if (f_inf(z) && as != ps) begin
                r   = 32'h7FC0_0000;
                inv = 1'b1;
            end else begin
                r = {ps, 8'hFF, 23'h0};
            end
        end else if (f_zero(x) || f_zero(y)) begin
            if (f_inf(z)) begin
                r   = {as, 8'hFF, 23'h0};
                tag = "R9";
            end else if (f_zero(z)) begin
                r   = (as == ps) ? {as, 31'h0} : {(rm == 2'b11), 31'h0};
                tag = "R10";
            end else begin
                r   = {as, z[30:0]};
                tag = "R9";
            end
        end else if (f_inf(z)) begin
            r   = {as, 8'hFF, 23'h0};
            tag = "R8";
        end else begin
            cmp = 1'b1;
            tag = "R11";
        end
    endtask

    task automatic apply_check(input logic [31:0] z, x, y, input bit np, na,
                               input logic [1:0] rm);
        logic [31:0] er;
        bit          ei, ec;
        string       tag;
        @(negedge clk);
        z_bits   = z;
        x_bits   = x;
        y_bits   = y;
        neg_prod = np;
        neg_add  = na;
        rmode    = rm;
        model(z, x, y, np, na, rm, er, ei, ec, tag);
        #1;
        n_checks++;
        // invalid compared on every vector: R12; classes and signs: R1, R2
        if (result !== er || invalid !== ei || compute !== ec) begin
            n_fails++;
            $display("FAIL %s (R1/R2/R12) z=%h x=%h y=%h np=%0b na=%0b rm=%0d: got r=%h inv=%0b cmp=%0b, expected r=%h inv=%0b cmp=%0b",
                     tag, z, x, y, np, na, rm, result, invalid, compute, er, ei, ec);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!done && cyc >= WATCHDOG_CYC) begin
            n_fails++;
            $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        z_bits   = 32'h0;
        x_bits   = 32'h0;
        y_bits   = 32'h0;
        neg_prod = 1'b0;
        neg_add  = 1'b0;
        rmode    = 2'b00;

        // Idle inputs (all zero) give +0 with no flag: R10
        apply_check(32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 2'b00);

        // Directed corner cases
        // R4: payload and sign kept, only bit 22 set
        apply_check(32'h3F80_0000, 32'hFF80_1234, 32'h4000_0000, 1'b0, 1'b0, 2'b00);
        // R3: y signalling beats z quiet
        apply_check(32'h7FC0_0001, 32'h3F80_0000, 32'h7F80_0005, 1'b0, 1'b0, 2'b00);
        // R10: cancellation under each rounding mode
        for (int m = 0; m < 4; m++)
            apply_check(32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 1'b0, 1'b0, 2'(m));
        // R7: same-signed infinities after negate-addend flip
        apply_check(32'hFF80_0000, 32'h7F80_0000, 32'h3F80_0000, 1'b0, 1'b1, 2'b00);
        // R11: subnormal multiplicands still go to the datapath
        apply_check(32'h0000_0001, 32'h0000_0001, 32'h807F_FFFF, 1'b1, 1'b0, 2'b11);

        // Exhaustive class/sign sweep with every variant and rounding mode (R2 variants)
        for (int iz = 0; iz < N_SAMP; iz++)
            for (int ix = 0; ix < N_SAMP; ix++)
                for (int iy = 0; iy < N_SAMP; iy++)
                    for (int f = 0; f < 4; f++)
                        for (int m = 0; m < 4; m++)
                            apply_check(samp(iz), samp(ix), samp(iy),
                                        f[1], f[0], 2'(m));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule